// File: doc/BRIEF.md
# Root-Hub Port Attach Detector

This block keeps the attach-related status of a single downstream port of a root hub. It watches a connect line and a low-speed line from the port's analog front end. It reports whether a device is present, whether that device runs at low speed, and whether the port is enabled. It also keeps two sticky change flags: one for the connection and one for the enable state. Software clears a change flag by writing a one to its bit.

When the host controller reset input is asserted, the attach state machine is held in reset and the port shows a virtual disconnect. The connect and low-speed bits read zero even if a device is plugged in. The port is disabled, and both change flags are set. After the controller reset is released, a settle timer counts bit-time ticks. Line detection resumes only once the full settle window has passed. A power-on reset (`rst_n`) starts the same settle window, but it leaves the change flags clear.

Top module: `usb_port_attach`

## Requirements
- R1: While `rst_n` is low, every bit of `port_sts` is 0.
- R2: On every clock edge where `ctl_reset` is high, connect status (bit 0), enable (bit 2) and low-speed (bit 8) are cleared, whatever the lines show.
- R3: On every clock edge where `ctl_reset` is high, connect change (bit 1) and enable change (bit 3) are set. Register writes made during that time have no effect.
- R4: After `ctl_reset` falls, or after `rst_n` rises, bits 0 and 8 stay 0 until `SETTLE_TICKS` (default 64) clock edges with `bit_tick` high have been counted. On the following clock edge they show the line state.
- R5: If `ctl_reset` is asserted again during the settle window, the tick count restarts from zero.
- R6: Once settled, any change of the connect status (bit 0) sets the connect change flag (bit 1).
- R7: A write with `wr_data` bit 1 set clears bit 1, and a write with bit 3 set clears bit 3. A zero in those bits leaves the flag alone. A hardware set in the same cycle wins over the clear.
- R8: A write loads the enable bit (bit 2) from `wr_data` bit 2, but it can set the bit only while a device is connected. A disconnect clears the enable bit on the same edge.
- R9: Once settled, bit 8 equals `line_present` AND `line_lowspd`.
- R10: `port_sts` holds connect at bit 0, connect change at bit 1, enable at bit 2, enable change at bit 3 and low-speed at bit 8. All other bits read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ctl_reset | input | 1 | Host controller reset, active high |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| line_present | input | 1 | A device is physically attached (synchronous) |
| line_lowspd | input | 1 | The attached device signals low speed (synchronous) |
| wr_valid | input | 1 | Write strobe for the port status word |
| wr_data | input | 16 | Write data: bit 1 and bit 3 write-one-to-clear, bit 2 enable |
| port_sts | output | 16 | Port status word |

## Verification
The assertions assume that `line_present`, `line_lowspd` and `bit_tick` are already synchronous to `clk`. They also assume that a register write is a single-cycle strobe, with `wr_data` qualified by `wr_valid`. The stimulus changes every input just after a falling clock edge and holds `bit_tick` as a plain level across a counted number of cycles. Because of this, the number of ticks seen by the settle timer is known exactly. Each combination of connect and low-speed line levels is swept, and for each one all sixteen values of the writable low nibble are applied.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;

  localparam int STS_W   = 16;
  localparam int CCS_BIT = 0;
  localparam int CSC_BIT = 1;
  localparam int PE_BIT  = 2;
  localparam int PEC_BIT = 3;
  localparam int LS_BIT  = 8;

  typedef enum logic [0:0] {
    PH_SETTLE = 1'b0,
    PH_TRACK  = 1'b1
  } det_phase_e;

  typedef struct packed {
    logic ls;
    logic pec;
    logic pe;
    logic csc;
    logic ccs;
  } port_bits_t;

endpackage

// File: rtl/usb_port_settle_timer.sv
module usb_port_settle_timer
  import usb_port_pkg::*;
#(
  parameter int SETTLE_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_reset,
  input  logic bit_tick,
  output logic trk
);

  localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

  det_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Clock enable: a controller reset, or a tick while still settling
  assign cnt_en = ctl_reset | ((phase_q == PH_SETTLE) & bit_tick);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (ctl_reset) begin
      phase_d = PH_SETTLE;
      cnt_d   = '0;
    end else if (cnt_q == LAST) begin
      phase_d = PH_TRACK;
      cnt_d   = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SETTLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign trk = (phase_q == PH_TRACK);

endmodule

// File: rtl/usb_port_wr_decode.sv
module usb_port_wr_decode
  import usb_port_pkg::*;
(
  input  logic             ctl_reset,
  input  logic             wr_valid,
  input  logic [STS_W-1:0] wr_data,
  output logic             clr_csc,
  output logic             clr_pec,
  output logic             pe_wr,
  output logic             pe_val
);

  logic wr_ok;

  // Writes are dropped while the controller is held in reset
  assign wr_ok   = wr_valid & ~ctl_reset;
  assign clr_csc = wr_ok & wr_data[CSC_BIT];
  assign clr_pec = wr_ok & wr_data[PEC_BIT];
  assign pe_wr   = wr_ok;
  assign pe_val  = wr_data[PE_BIT];

endmodule

// File: rtl/usb_port_status_regs.sv
module usb_port_status_regs
  import usb_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_reset,
  input  logic       trk,
  input  logic       line_present,
  input  logic       line_lowspd,
  input  logic       clr_csc,
  input  logic       clr_pec,
  input  logic       pe_wr,
  input  logic       pe_val,
  output port_bits_t bits
);

  port_bits_t bits_q, bits_d;
  logic       conn_d;
  logic       reg_en;

  assign reg_en = ctl_reset | trk | clr_csc | clr_pec | pe_wr;

  always_comb begin
    conn_d     = trk & line_present & ~ctl_reset;
    bits_d.ccs = conn_d;
    bits_d.ls  = conn_d & line_lowspd;
    bits_d.csc = ctl_reset | (conn_d != bits_q.ccs) | (bits_q.csc & ~clr_csc);
    bits_d.pec = ctl_reset | (bits_q.pec & ~clr_pec);
    bits_d.pe  = conn_d & (pe_wr ? pe_val : bits_q.pe);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (reg_en) begin
      bits_q <= bits_d;
    end
  end

  assign bits = bits_q;

endmodule

// File: rtl/usb_port_attach.sv
module usb_port_attach
  import usb_port_pkg::*;
#(
  parameter int SETTLE_TICKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_reset,
  input  logic             bit_tick,
  input  logic             line_present,
  input  logic             line_lowspd,
  input  logic             wr_valid,
  input  logic [STS_W-1:0] wr_data,
  output logic [STS_W-1:0] port_sts
);

  logic       trk;
  logic       clr_csc, clr_pec, pe_wr, pe_val;
  port_bits_t bits;

  usb_port_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_reset (ctl_reset),
    .bit_tick  (bit_tick),
    .trk       (trk)
  );

  usb_port_wr_decode u_wr (
    .ctl_reset (ctl_reset),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .clr_csc   (clr_csc),
    .clr_pec   (clr_pec),
    .pe_wr     (pe_wr),
    .pe_val    (pe_val)
  );

  usb_port_status_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_reset    (ctl_reset),
    .trk          (trk),
    .line_present (line_present),
    .line_lowspd  (line_lowspd),
    .clr_csc      (clr_csc),
    .clr_pec      (clr_pec),
    .pe_wr        (pe_wr),
    .pe_val       (pe_val),
    .bits         (bits)
  );

  always_comb begin
    port_sts          = '0;
    port_sts[CCS_BIT] = bits.ccs;
    port_sts[CSC_BIT] = bits.csc;
    port_sts[PE_BIT]  = bits.pe;
    port_sts[PEC_BIT] = bits.pec;
    port_sts[LS_BIT]  = bits.ls;
  end

endmodule

// File: rtl/usb_port_attach_chk.sv
module usb_port_attach_chk
  import usb_port_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_reset,
  input logic             wr_valid,
  input logic [STS_W-1:0] wr_data,
  input logic             trk,
  input logic [STS_W-1:0] sts
);

  a_r2_reset_hides_port: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (!sts[CCS_BIT] && !sts[PE_BIT] && !sts[LS_BIT]));

  a_r3_reset_sets_changes: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset |=> (sts[CSC_BIT] && sts[PEC_BIT]));

  a_r4_settle_hides_connect: assert property (@(posedge clk) disable iff (!rst_n)
    !trk |-> (!sts[CCS_BIT] && !sts[LS_BIT]));

  a_r6_attach_flags_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[CCS_BIT]) |-> sts[CSC_BIT]);

  a_r6_detach_flags_change: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[CCS_BIT]) |-> sts[CSC_BIT]);

  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[CSC_BIT]) |-> $past(wr_valid && wr_data[CSC_BIT]));

  a_r7_pec_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sts[PEC_BIT]) |-> $past(wr_valid && wr_data[PEC_BIT]));

  a_r8_enable_needs_connect: assert property (@(posedge clk) disable iff (!rst_n)
    sts[PE_BIT] |-> sts[CCS_BIT]);

  a_r9_lowspd_needs_connect: assert property (@(posedge clk) disable iff (!rst_n)
    sts[LS_BIT] |-> sts[CCS_BIT]);

endmodule

bind usb_port_attach usb_port_attach_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_reset (ctl_reset),
  .wr_valid  (wr_valid),
  .wr_data   (wr_data),
  .trk       (trk),
  .sts       (port_sts)
);

// File: tb/usb_port_attach_bench.sv
`timescale 1ns/1ps
module usb_port_attach_bench;

  logic        clk;
  logic        rst_n;
  logic        ctl_reset;
  logic        bit_tick;
  logic        line_present;
  logic        line_lowspd;
  logic        wr_valid;
  logic [15:0] wr_data;
  logic [15:0] port_sts;

  int nvec = 0;
  int nbad = 0;
  bit done = 0;

  usb_port_attach u_usb_port_attach (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_reset    (ctl_reset),
    .bit_tick     (bit_tick),
    .line_present (line_present),
    .line_lowspd  (line_lowspd),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .port_sts     (port_sts)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] mk(logic ccs, logic csc, logic pe, logic pec, logic ls);
    logic [15:0] v;
    v    = '0;
    v[0] = ccs;
    v[1] = csc;
    v[2] = pe;
    v[3] = pec;
    v[8] = ls;
    return v;
  endfunction

  task automatic check(string req, logic [15:0] exp);
    nvec++;
    if (port_sts !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, port_sts, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    bit_tick = 1'b1;
    repeat (n) @(negedge clk);
    bit_tick = 1'b0;
  endtask

  task automatic wr(logic [15:0] w);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic e_ccs, e_csc, e_pe, e_pec, e_ls;
    rst_n        = 1'b0;
    ctl_reset    = 1'b0;
    bit_tick     = 1'b0;
    line_present = 1'b1;
    line_lowspd  = 1'b1;
    wr_valid     = 1'b0;
    wr_data      = '0;
    idle(2);
    check("R1 power reset", 16'h0000);
    rst_n = 1'b1;
    ticks(63);
    idle(2);
    check("R4 power-up settle hidden", 16'h0000);
    ticks(1);
    idle(1);
    check("R4 R6 power-up detect", mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b1));

    for (int p = 0; p < 4; p++) begin
      line_present = p[0];
      line_lowspd  = p[1];
      // virtual disconnect; a W1C write during it must be ignored
      ctl_reset = 1'b1;
      idle(1);
      wr(16'h000E);
      idle(1);
      check("R2 R3 virtual disconnect", mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
      ctl_reset = 1'b0;
      if (p == 3) begin
        ticks(40);
        ctl_reset = 1'b1;
        idle(1);
        ctl_reset = 1'b0;
        ticks(63);
        idle(1);
        check("R5 settle restarted", mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
      end else begin
        ticks(63);
        idle(3);
        check("R4 settle hidden", mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
      end
      ticks(1);
      idle(1);
      e_ccs = p[0];
      e_ls  = p[0] & p[1];
      e_csc = 1'b1;
      e_pec = 1'b1;
      e_pe  = 1'b0;
      check("R4 R9 re-detect", mk(e_ccs, e_csc, e_pe, e_pec, e_ls));

      for (int w = 0; w < 16; w++) begin
        wr(16'(w) | 16'hF0F0);
        e_csc = e_csc & ~w[1];
        e_pec = e_pec & ~w[3];
        e_pe  = w[2] & e_ccs;
        check("R7 R8 R10 write sweep", mk(e_ccs, e_csc, e_pe, e_pec, e_ls));
      end

      if (p[0]) begin
        wr(16'h0004);
        check("R8 enable set", mk(1'b1, 1'b0, 1'b1, 1'b0, e_ls));
        line_present = 1'b0;
        idle(1);
        check("R6 R8 R9 detach", mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        wr(16'h0002);
        check("R7 clear csc", 16'h0000);
        line_present = 1'b1;
        wr(16'h0002);
        check("R7 hardware set wins", mk(1'b1, 1'b1, 1'b0, 1'b0, p[1]));
        line_lowspd = ~p[1];
        idle(1);
        check("R9 low-speed follows", mk(1'b1, 1'b1, 1'b0, 1'b0, ~p[1]));
        line_lowspd = p[1];
        idle(1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule